// File: doc/BRIEF.md
# Single-Operand ALU with Condition Codes

This block executes the one-operand instruction group of a 16-bit processor. Each cycle it may accept the upper part of an instruction word, an operand value that an earlier stage has already fetched, and the current condition codes. One clock later it presents the result, a write-back enable, the new condition codes and an illegal-opcode indication. Operand fetch, address generation and the memory write are handled outside the block.

The instruction input carries instruction bits 15:6. Bit 9 of this input is instruction bit 15 and selects byte mode. Bits 8:0 are the nine-bit opcode field. In byte mode only the low half of the operand is used, the sign is bit 7, and the upper half of the result is driven to zero so that the write-back stage can merge it. Each operation sets the flags by its own rules: rotates pass through carry, shifts derive V as N xor C, and increment, decrement, negate and the carry arithmetic detect overflow at fixed boundary values.

Top module: `sop_alu`

## Requirements
- R1: An operation presented with `in_valid` high appears on the outputs with `out_valid` high after exactly one rising clock edge. On a cycle with `in_valid` low, `out_valid` is low on the next cycle and result, flags and enables hold their previous values.
- R2: When `instr_op[9]` is 1 (byte mode), only `operand[7:0]` is used, N is result bit 7, Z tests the low 8 bits, and `result[15:8]` is 0.
- R3: Opcode 050 (octal) clears: the result is 0 and the flags become N=0 Z=1 V=0 C=0. Opcode 051 complements every bit and sets V=0 and C=1.
- R4: Opcodes 052 and 053 add 1 and subtract 1. V is set only when the operand was the largest positive value (increment) or the most negative value (decrement). C keeps its incoming value.
- R5: Opcode 054 forms the two's complement. V is set when the result is the most negative value, and C is set whenever the result is nonzero.
- R6: Opcode 055 adds incoming C. V is set when the operand was the largest positive value and C was 1, and C is set when the operand was all ones and C was 1. Opcode 056 subtracts incoming C. V is set when the result is the most negative value, and C is set when the operand was 0 and C was 1.
- R7: Opcode 060 rotates right and opcode 061 rotates left through carry. The bit shifted out becomes C, the old C enters the vacated end, and V equals N xor C.
- R8: Opcode 062 shifts right and keeps the sign bit, with the old bit 0 going to C. Opcode 063 shifts left with a zero fill, with the old sign bit going to C. Both set V to N xor C.
- R9: Opcode 057 drives `wr_en` low, presents the masked operand as the result, takes N and Z from it, and clears V and C.
- R10: Opcode 003 in word mode exchanges the two bytes. N and Z come from the low byte of the result, and V and C are cleared.
- R11: Every other opcode, including 003 in byte mode, raises `illegal`, drives the result to 0 and `wr_en` low, and passes the incoming flags out unchanged.
- R12: While `rst` is high at a rising edge, all outputs become 0 on that edge.

Flags are packed as {N, Z, V, C} in bits 3:0 of `flags_in` and `flags_out`. N is always the sign bit of the result and Z is set when the masked result is zero, except where a requirement above states otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| instr_op | input | 10 | Instruction bits 15:6: byte flag in bit 9, opcode in bits 8:0 |
| operand | input | 16 | Fetched operand value |
| flags_in | input | 4 | Incoming {N, Z, V, C} |
| out_valid | output | 1 | Registered result is from the previous cycle's operation |
| result | output | 16 | Value to write back |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 4 | New {N, Z, V, C} |
| illegal | output | 1 | Opcode is not part of this group |

## Verification
Every output is due on the first rising edge after the edge that samples `in_valid`. The bench therefore changes inputs on a falling edge and reads the outputs on the following falling edge, halfway between the capturing edge and the next one. After an operation it drops `in_valid` for one cycle, which confirms that `out_valid` falls while the other outputs hold. The reset checks read the outputs on the falling edge after a reset edge.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // width of the opcode field taken from instruction bits 14:6
  localparam int OPC_W = 9;

  localparam logic [OPC_W-1:0] CODE_SWAP = 9'o003;
  localparam logic [OPC_W-1:0] CODE_CLR  = 9'o050;
  localparam logic [OPC_W-1:0] CODE_COM  = 9'o051;
  localparam logic [OPC_W-1:0] CODE_INC  = 9'o052;
  localparam logic [OPC_W-1:0] CODE_DEC  = 9'o053;
  localparam logic [OPC_W-1:0] CODE_NEG  = 9'o054;
  localparam logic [OPC_W-1:0] CODE_ADC  = 9'o055;
  localparam logic [OPC_W-1:0] CODE_SBC  = 9'o056;
  localparam logic [OPC_W-1:0] CODE_TST  = 9'o057;
  localparam logic [OPC_W-1:0] CODE_ROR  = 9'o060;
  localparam logic [OPC_W-1:0] CODE_ROL  = 9'o061;
  localparam logic [OPC_W-1:0] CODE_ASR  = 9'o062;
  localparam logic [OPC_W-1:0] CODE_ASL  = 9'o063;

  typedef enum logic [3:0] {
    OP_CLR, OP_COM, OP_INC, OP_DEC, OP_NEG, OP_ADC, OP_SBC,
    OP_TST, OP_ROR, OP_ROL, OP_ASR, OP_ASL, OP_SWAP, OP_BAD
  } sop_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccode_t;

endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
(
  input  logic [OPC_W:0] instr_op,
  output sop_op_e        op,
  output logic           byte_mode,
  output logic           illegal
);

  logic [OPC_W-1:0] code;

  assign code      = instr_op[OPC_W-1:0];
  assign byte_mode = instr_op[OPC_W];

  always_comb begin
    op = OP_BAD;
    unique case (code)
      CODE_CLR:  op = OP_CLR;
      CODE_COM:  op = OP_COM;
      CODE_INC:  op = OP_INC;
      CODE_DEC:  op = OP_DEC;
      CODE_NEG:  op = OP_NEG;
      CODE_ADC:  op = OP_ADC;
      CODE_SBC:  op = OP_SBC;
      CODE_TST:  op = OP_TST;
      CODE_ROR:  op = OP_ROR;
      CODE_ROL:  op = OP_ROL;
      CODE_ASR:  op = OP_ASR;
      CODE_ASL:  op = OP_ASL;
      CODE_SWAP: op = byte_mode ? OP_BAD : OP_SWAP;
      default:   op = OP_BAD;
    endcase
  end

  assign illegal = (op == OP_BAD);

endmodule

// File: rtl/sop_lane.sv
module sop_lane
  import sop_pkg::*;
#(
  parameter int LW = 16
) (
  input  sop_op_e         op,
  input  logic [LW-1:0]   opnd,
  input  ccode_t          cc_in,
  output logic [LW-1:0]   res,
  output ccode_t          cc_out,
  output logic            wr
);

  localparam logic [LW-1:0] MAX_POS = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MIN_NEG = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] ONES    = {LW{1'b1}};
  localparam logic [LW-1:0] ZERO    = '0;
  localparam logic [LW-1:0] ONE     = {{(LW-1){1'b0}}, 1'b1};

  logic [LW-1:0] cin_ext;
  logic          c_new;
  logic          v_new;
  logic          v_is_nxc;
  logic          keep_nz;

  assign cin_ext = {{(LW-1){1'b0}}, cc_in.c};

  always_comb begin
    res      = opnd;
    c_new    = cc_in.c;
    v_new    = 1'b0;
    v_is_nxc = 1'b0;
    keep_nz  = 1'b0;
    wr       = 1'b1;
    unique case (op)
      OP_CLR: begin
        res   = ZERO;
        c_new = 1'b0;
      end
      OP_COM: begin
        res   = ~opnd;
        c_new = 1'b1;
      end
      OP_INC: begin
        res   = opnd + ONE;
        v_new = (opnd == MAX_POS);
      end
      OP_DEC: begin
        res   = opnd - ONE;
        v_new = (opnd == MIN_NEG);
      end
      OP_NEG: begin
        res   = ZERO - opnd;
        v_new = (res == MIN_NEG);
        c_new = (res != ZERO);
      end
      OP_ADC: begin
        res   = opnd + cin_ext;
        v_new = (opnd == MAX_POS) && cc_in.c;
        c_new = (opnd == ONES) && cc_in.c;
      end
      OP_SBC: begin
        res   = opnd - cin_ext;
        v_new = (res == MIN_NEG);
        c_new = (opnd == ZERO) && cc_in.c;
      end
      OP_TST: begin
        res   = opnd;
        c_new = 1'b0;
        wr    = 1'b0;
      end
      OP_ROR: begin
        res      = {cc_in.c, opnd[LW-1:1]};
        c_new    = opnd[0];
        v_is_nxc = 1'b1;
      end
      OP_ROL: begin
        res      = {opnd[LW-2:0], cc_in.c};
        c_new    = opnd[LW-1];
        v_is_nxc = 1'b1;
      end
      OP_ASR: begin
        res      = {opnd[LW-1], opnd[LW-1:1]};
        c_new    = opnd[0];
        v_is_nxc = 1'b1;
      end
      OP_ASL: begin
        res      = {opnd[LW-2:0], 1'b0};
        c_new    = opnd[LW-1];
        v_is_nxc = 1'b1;
      end
      default: begin
        // swap and undefined codes are resolved outside the lane
        res     = ZERO;
        c_new   = cc_in.c;
        v_new   = cc_in.v;
        keep_nz = 1'b1;
        wr      = 1'b0;
      end
    endcase
  end

  always_comb begin
    cc_out.n = keep_nz ? cc_in.n : res[LW-1];
    cc_out.z = keep_nz ? cc_in.z : (res == ZERO);
    cc_out.c = c_new;
    cc_out.v = v_is_nxc ? (res[LW-1] ^ c_new) : v_new;
  end

endmodule

// File: rtl/sop_swap.sv
module sop_swap
  import sop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output ccode_t       cc_out
);

  localparam int H = W / 2;

  assign res = {opnd[H-1:0], opnd[W-1:H]};

  always_comb begin
    cc_out.n = res[H-1];
    cc_out.z = (res[H-1:0] == '0);
    cc_out.v = 1'b0;
    cc_out.c = 1'b0;
  end

endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import sop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [OPC_W:0] instr_op,
  input  logic [W-1:0]   operand,
  input  logic [3:0]     flags_in,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           wr_en,
  output logic [3:0]     flags_out,
  output logic           illegal
);

  localparam int H      = W / 2;
  localparam int NLANES = 2;   // lane 0: full word, lane 1: low byte

  sop_op_e op;
  logic    byte_mode;
  logic    dec_bad;
  ccode_t  cc_in;

  assign cc_in = ccode_t'(flags_in);

  sop_decode u_dec (
    .instr_op  (instr_op),
    .op        (op),
    .byte_mode (byte_mode),
    .illegal   (dec_bad)
  );

  logic   [NLANES-1:0][W-1:0] lane_res;
  ccode_t [NLANES-1:0]        lane_cc;
  logic   [NLANES-1:0]        lane_wr;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? W : H;
    logic [LW-1:0] lres;

    sop_lane #(.LW(LW)) u_lane (
      .op     (op),
      .opnd   (operand[LW-1:0]),
      .cc_in  (cc_in),
      .res    (lres),
      .cc_out (lane_cc[g]),
      .wr     (lane_wr[g])
    );

    assign lane_res[g] = W'(lres);
  end

  logic   [W-1:0] swap_res;
  ccode_t         swap_cc;

  sop_swap #(.W(W)) u_swap (
    .opnd   (operand),
    .res    (swap_res),
    .cc_out (swap_cc)
  );

  logic   [W-1:0] nxt_res;
  ccode_t         nxt_cc;
  logic           nxt_wr;

  always_comb begin
    if (dec_bad) begin
      nxt_res = '0;
      nxt_cc  = cc_in;
      nxt_wr  = 1'b0;
    end else if (op == OP_SWAP) begin
      nxt_res = swap_res;
      nxt_cc  = swap_cc;
      nxt_wr  = 1'b1;
    end else begin
      nxt_res = lane_res[byte_mode];
      nxt_cc  = lane_cc[byte_mode];
      nxt_wr  = lane_wr[byte_mode];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      flags_out <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        wr_en     <= nxt_wr;
        flags_out <= nxt_cc;
        illegal   <= dec_bad;
      end
    end
  end

endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk
  import sop_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [OPC_W:0] instr_op,
  input logic [W-1:0]   operand,
  input logic [3:0]     flags_in,
  input logic           out_valid,
  input logic [W-1:0]   result,
  input logic           wr_en,
  input logic [3:0]     flags_out,
  input logic           illegal
);

  localparam int H = W / 2;

  logic [OPC_W-1:0] code;
  assign code = instr_op[OPC_W-1:0];

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

  AST_BYTE_HIGH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    in_valid && instr_op[OPC_W] |=> result[W-1:H] == '0); // R2

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == CODE_CLR |=> result == '0 && flags_out == 4'b0100 && wr_en); // R3

  AST_INCDEC_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
    in_valid && (code == CODE_INC || code == CODE_DEC) |=> flags_out[0] == $past(flags_in[0])); // R4

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == CODE_NEG |=> flags_out[0] == (result != '0)); // R5

  AST_ROTATE_V: assert property (@(posedge clk) disable iff (rst)
    in_valid && (code == CODE_ROR || code == CODE_ROL) |=> flags_out[1] == (flags_out[3] ^ flags_out[0])); // R7

  AST_SHIFT_V: assert property (@(posedge clk) disable iff (rst)
    in_valid && (code == CODE_ASR || code == CODE_ASL) |=> flags_out[1] == (flags_out[3] ^ flags_out[0])); // R8

  AST_TST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && code == CODE_TST |=> !wr_en && flags_out[1:0] == 2'b00); // R9

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !illegal || (!wr_en && result == '0 && flags_out == $past(flags_in))); // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !wr_en && !illegal && result == '0 && flags_out == '0); // R12

endmodule

bind sop_alu sop_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_sop_alu.sv
module tb_sop_alu;

  localparam int W  = 16;
  localparam int NV = 32;
  // vector: instr_op(10) operand(16) flags_in(4) result(16) wr(1) flags_out(4) illegal(1)
  localparam int VW = 52;

  localparam logic [VW-1:0] VEC [NV] = '{
    {10'o0050, 16'h1234, 4'b1111, 16'h0000, 1'b1, 4'b0100, 1'b0},
    {10'o0051, 16'h00FF, 4'b0000, 16'hFF00, 1'b1, 4'b1001, 1'b0},
    {10'o1051, 16'h12FF, 4'b0000, 16'h0000, 1'b1, 4'b0101, 1'b0},
    {10'o0052, 16'h7FFF, 4'b0001, 16'h8000, 1'b1, 4'b1011, 1'b0},
    {10'o1052, 16'h017F, 4'b0000, 16'h0080, 1'b1, 4'b1010, 1'b0},
    {10'o0052, 16'hFFFF, 4'b0000, 16'h0000, 1'b1, 4'b0100, 1'b0},
    {10'o0053, 16'h8000, 4'b0001, 16'h7FFF, 1'b1, 4'b0011, 1'b0},
    {10'o1053, 16'h0001, 4'b1000, 16'h0000, 1'b1, 4'b0100, 1'b0},
    {10'o0054, 16'h0001, 4'b0000, 16'hFFFF, 1'b1, 4'b1001, 1'b0},
    {10'o0054, 16'h8000, 4'b0000, 16'h8000, 1'b1, 4'b1011, 1'b0},
    {10'o0054, 16'h0000, 4'b0001, 16'h0000, 1'b1, 4'b0100, 1'b0},
    {10'o0055, 16'h7FFF, 4'b0001, 16'h8000, 1'b1, 4'b1010, 1'b0},
    {10'o0055, 16'hFFFF, 4'b0001, 16'h0000, 1'b1, 4'b0101, 1'b0},
    {10'o1055, 16'h00FF, 4'b0000, 16'h00FF, 1'b1, 4'b1000, 1'b0},
    {10'o0056, 16'h0000, 4'b0001, 16'hFFFF, 1'b1, 4'b1001, 1'b0},
    {10'o0056, 16'h8001, 4'b0001, 16'h8000, 1'b1, 4'b1010, 1'b0},
    {10'o0057, 16'h8000, 4'b0111, 16'h8000, 1'b0, 4'b1000, 1'b0},
    {10'o1057, 16'h8000, 4'b0000, 16'h0000, 1'b0, 4'b0100, 1'b0},
    {10'o0060, 16'h0001, 4'b0000, 16'h0000, 1'b1, 4'b0111, 1'b0},
    {10'o0060, 16'h0002, 4'b0001, 16'h8001, 1'b1, 4'b1010, 1'b0},
    {10'o1060, 16'h0081, 4'b0001, 16'h00C0, 1'b1, 4'b1001, 1'b0},
    {10'o0061, 16'h8000, 4'b0000, 16'h0000, 1'b1, 4'b0111, 1'b0},
    {10'o1061, 16'h0040, 4'b0001, 16'h0081, 1'b1, 4'b1010, 1'b0},
    {10'o0062, 16'h8001, 4'b0000, 16'hC000, 1'b1, 4'b1001, 1'b0},
    {10'o1062, 16'h0002, 4'b0000, 16'h0001, 1'b1, 4'b0000, 1'b0},
    {10'o0063, 16'h4000, 4'b0000, 16'h8000, 1'b1, 4'b1010, 1'b0},
    {10'o1063, 16'h00C0, 4'b0000, 16'h0080, 1'b1, 4'b1001, 1'b0},
    {10'o0003, 16'h80FF, 4'b1111, 16'hFF80, 1'b1, 4'b1000, 1'b0},
    {10'o0003, 16'h00AB, 4'b0000, 16'hAB00, 1'b1, 4'b0100, 1'b0},
    {10'o1003, 16'h1234, 4'b1010, 16'h0000, 1'b0, 4'b1010, 1'b1},
    {10'o0064, 16'h5555, 4'b0101, 16'h0000, 1'b0, 4'b0101, 1'b1},
    {10'o0000, 16'hFFFF, 4'b0011, 16'h0000, 1'b0, 4'b0011, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [9:0]    instr_op = '0;
  logic [W-1:0]  operand = '0;
  logic [3:0]    flags_in = '0;
  logic          out_valid;
  logic [W-1:0]  result;
  logic          wr_en;
  logic [3:0]    flags_out;
  logic          illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  sop_alu #(.W(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr_op  (instr_op),
    .operand   (operand),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out),
    .illegal   (illegal)
  );

  function automatic string req_of(input logic [9:0] io);
    string base;
    case (io[8:0])
      9'o050, 9'o051: base = "R3";
      9'o052, 9'o053: base = "R4";
      9'o054:         base = "R5";
      9'o055, 9'o056: base = "R6";
      9'o057:         base = "R9";
      9'o060, 9'o061: base = "R7";
      9'o062, 9'o063: base = "R8";
      9'o003:         base = io[9] ? "R11" : "R10";
      default:        base = "R11";
    endcase
    if (io[9] && base != "R11") base = {"R2 ", base};
    return base;
  endfunction

  task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,result,wr,flags,illegal} actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: outputs after reset
    check("R12 reset", {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0}, 39'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      in_valid = 1'b1;
      instr_op = v[51:42];
      operand  = v[41:26];
      flags_in = v[25:22];
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(v[51:42]),
            {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0},
            {1'b0, 1'b1, v[21:0], 16'h0});
    end

    // R1: an idle cycle lowers out_valid and holds the last outputs
    @(negedge clk);
    instr_op = 10'o0050;
    operand  = 16'hFFFF;
    check("R1 idle hold", {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0},
          {1'b0, 1'b0, 16'h0000, 1'b0, 4'b0011, 1'b1, 16'h0});

    // R1: back-to-back operations, one result per cycle
    in_valid = 1'b1;
    instr_op = 10'o0052;
    operand  = 16'h0010;
    flags_in = 4'b0000;
    @(negedge clk);
    instr_op = 10'o0053;
    operand  = 16'h0010;
    check("R1 first of pair", {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0},
          {1'b0, 1'b1, 16'h0011, 1'b1, 4'b0000, 1'b0, 16'h0});
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second of pair", {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0},
          {1'b0, 1'b1, 16'h000F, 1'b1, 4'b0000, 1'b0, 16'h0});

    // R12: reset in the middle of a run clears a live result
    in_valid = 1'b1;
    instr_op = 10'o0051;
    operand  = 16'h0000;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check("R12 mid-run reset", {1'b0, out_valid, result, wr_en, flags_out, illegal, 16'h0}, 39'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule